// File: doc/BRIEF.md
# Loop Replay Buffer for Decoded Control Words

This block sits between the instruction decoder and the execute stage of a small signal-processing pipeline that runs hardware loops. When a loop is announced, the block copies the decoder's control word for each body instruction into a small local store as those words pass through to execute. The store is indexed by the instruction's position in the loop body.

For every later pass of that loop, the block turns fetch and decode off. It then feeds execute from the store, walking the positions in order. When the last pass is done, fetch and decode come back on and execute again sees the live decoder.

Loops that are too long for the store, loops that run only once, and any loop started while the buffer is switched off run through fetch and decode on every pass. Execute receives the same word sequence whichever path delivered it.

Top module: `loop_replay_buf`

## Requirements
- R1: After reset, fetch_en is 1 and the block is transparent: exe_valid equals dec_valid and exe_word equals dec_word.
- R2: A word counts as accepted in a cycle where exe_valid is 1 and stall is 0. Outside a buffered loop, fetch_en stays 1 and execute receives the decoder output unchanged.
- R3: A loop is buffered when loop_start is sampled at 1 with buf_en 1, loop_len from 1 to DEPTH (16) and loop_iters of at least 2. The next loop_len accepted decoder words are then stored at positions 0 to loop_len-1 and are also forwarded to execute. fetch_en stays 1 while they pass.
- R4: From the cycle after the word at position loop_len-1 is accepted, fetch_en is 0. It stays 0 until (loop_iters-1)*loop_len further words have been accepted.
- R5: While fetch_en is 0, exe_valid is 1 and exe_word is the stored word at the current position. The position advances by one per accepted word and wraps from loop_len-1 back to 0. Each wrap ends one pass.
- R6: In the cycle after the last replayed word is accepted, fetch_en is 1 again and execute again sees the decoder output.
- R7: A loop_len greater than 16 bypasses the buffer, and fetch_en stays 1 for the whole loop.
- R8: A loop_iters of 1 never uses the buffer, and fetch_en stays 1.
- R9: With buf_en at 0, loops never use the buffer, and fetch_en stays 1.
- R10: While stall is 1, neither the store position nor the replay position moves. During replay, exe_word is held from one stalled cycle to the next.
- R11: The sequence of accepted words is identical with buf_en at 1 and at 0. With no stalls or bubbles, the buffered run has exactly (loop_iters-1)*loop_len fewer cycles with fetch_en at 1.
- R12: A cycle with dec_valid 0 during the first pass stores nothing and does not advance the store position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_en | input | 1 | 1 lets eligible loops use the buffer |
| loop_start | input | 1 | One-cycle pulse announcing a loop; body words follow |
| loop_len | input | 5 | Loop body length in instructions |
| loop_iters | input | 8 | Number of passes through the body |
| stall | input | 1 | Execute cannot accept a word this cycle |
| dec_valid | input | 1 | Decoder output is valid |
| dec_word | input | 32 | Decoded control word from the decoder |
| fetch_en | output | 1 | Enable for the fetch and decode stages |
| exe_valid | output | 1 | exe_word is valid for execute |
| exe_word | output | 32 | Control word selected for execute |

## Verification
The delicate cycles are those where a stall lands on a boundary cycle. One boundary is the acceptance of the last first-pass word, where storing ends and replay begins. The other is the final wrap, where replay hands back to the decoder. Random stalls and decoder bubbles are injected at every cycle across loops of length 1, 16 and others, so both boundaries are hit while stall is high. A behavioural model predicts fetch_en for every cycle from the count of accepted words alone. Each accepted word is compared against the fully unrolled loop sequence, so a skipped, doubled or early-exiting position shows up as a mismatch.

// File: rtl/lrb_pkg.sv
// Package: shared parameters and state encoding for the loop replay buffer.
// Assumes: one loop active at a time; DEPTH is a power of two.
package lrb_pkg;
    localparam int DEPTH  = 16;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 8;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int LEN_W  = $clog2(DEPTH + 1);

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_REPLAY  = 2'd2
    } lrb_state_e;
endpackage

// File: rtl/lrb_store.sv
// Module: word store holding one decoded control word per loop-body position.
// Assumes: one write and one asynchronous read per cycle; contents need no reset.
module lrb_store #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Write the captured word at its body position.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the word at the replay position.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/lrb_seq.sv
// Module: loop sequencer. Decides buffer eligibility, steps the store and
// replay positions, and counts remaining passes.
// Assumes: loop_start only arrives while no buffered loop is in flight.
module lrb_seq
    import lrb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_en,
    input  logic             loop_start,
    input  logic [LEN_W-1:0] loop_len,
    input  logic [CNT_W-1:0] loop_iters,
    input  logic             stall,
    input  logic             dec_valid,
    output logic             fetch_en,
    output logic             sel_buf,
    output logic             we,
    output logic [IDX_W-1:0] waddr,
    output logic [IDX_W-1:0] raddr
);
    lrb_state_e       state_q;
    logic [IDX_W-1:0] wr_idx_q, rd_idx_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] left_q;
    logic             eligible, cap_fire, rep_fire, cap_last, rep_wrap;

    // Work out whether a new loop may use the buffer and which positions end a pass.
    always_comb begin
        eligible = buf_en && (loop_len != '0) && (loop_len <= LEN_W'(DEPTH))
                   && (loop_iters >= CNT_W'(2));
        cap_fire = (state_q == ST_CAPTURE) && dec_valid && !stall;
        rep_fire = (state_q == ST_REPLAY) && !stall;
        cap_last = (LEN_W'(wr_idx_q) == len_q - LEN_W'(1));
        rep_wrap = (LEN_W'(rd_idx_q) == len_q - LEN_W'(1));
    end

    // Advance the state, the positions and the pass counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_PASS;
            wr_idx_q <= '0;
            rd_idx_q <= '0;
            len_q    <= '0;
            left_q   <= '0;
        end else begin
            case (state_q)
                ST_PASS: begin
                    if (loop_start && eligible) begin
                        state_q <= ST_CAPTURE;
                        len_q   <= loop_len;
                        left_q  <= loop_iters;
                    end
                end
                ST_CAPTURE: begin
                    if (cap_fire) begin
                        if (cap_last) begin
                            state_q  <= ST_REPLAY;
                            wr_idx_q <= '0;
                            left_q   <= left_q - CNT_W'(1);
                        end else begin
                            wr_idx_q <= wr_idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_REPLAY: begin
                    if (rep_fire) begin
                        if (rep_wrap) begin
                            rd_idx_q <= '0;
                            if (left_q == CNT_W'(1)) state_q <= ST_PASS;
                            else left_q <= left_q - CNT_W'(1);
                        end else begin
                            rd_idx_q <= rd_idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ST_PASS;
            endcase
        end
    end

    // Drive the fetch gate, the selector and the store ports.
    always_comb begin
        fetch_en = (state_q != ST_REPLAY);
        sel_buf  = (state_q == ST_REPLAY);
        we       = cap_fire;
        waddr    = wr_idx_q;
        raddr    = rd_idx_q;
    end

    // R10
    no_slip_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(wr_idx_q) && $stable(rd_idx_q)));
    // R7
    no_buffer_when_ineligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && loop_start && !eligible) |=> (state_q == ST_PASS));
    // R6
    fetch_back_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_fire && rep_wrap && left_q == CNT_W'(1)) |=> fetch_en);
    // R5
    replay_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPLAY) |-> (LEN_W'(rd_idx_q) < len_q && left_q != '0));
    // R12
    no_store_on_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && !dec_valid) |=> $stable(wr_idx_q));
endmodule

// File: rtl/lrb_mux.sv
// Module: execute-side selector between the live decoder and the store.
// Assumes: a stored word is always valid while the store is selected.
module lrb_mux #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_buf,
    input  logic              dec_valid,
    input  logic [WORD_W-1:0] dec_word,
    input  logic [WORD_W-1:0] buf_word,
    output logic              exe_valid,
    output logic [WORD_W-1:0] exe_word
);
    // Pick the control word and its valid flag for execute.
    always_comb begin
        exe_valid = sel_buf ? 1'b1 : dec_valid;
        exe_word  = sel_buf ? buf_word : dec_word;
    end

    // R5
    replay_always_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_buf |-> exe_valid);
endmodule

// File: rtl/loop_replay_buf.sv
// Module: top of the loop replay buffer. Ties the sequencer, the store and the
// execute selector together.
// Assumes: the fetch unit holds its position while fetch_en is 0 and resumes
// past the loop body once it rises again.
module loop_replay_buf
    import lrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_en,
    input  logic              loop_start,
    input  logic [LEN_W-1:0]  loop_len,
    input  logic [CNT_W-1:0]  loop_iters,
    input  logic              stall,
    input  logic              dec_valid,
    input  logic [WORD_W-1:0] dec_word,
    output logic              fetch_en,
    output logic              exe_valid,
    output logic [WORD_W-1:0] exe_word
);
    logic              sel_buf, we;
    logic [IDX_W-1:0]  waddr, raddr;
    logic [WORD_W-1:0] buf_word;

    lrb_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .loop_start(loop_start),
        .loop_len(loop_len), .loop_iters(loop_iters), .stall(stall),
        .dec_valid(dec_valid), .fetch_en(fetch_en), .sel_buf(sel_buf),
        .we(we), .waddr(waddr), .raddr(raddr)
    );

    lrb_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk(clk), .we(we), .waddr(waddr), .wdata(dec_word),
        .raddr(raddr), .rdata(buf_word)
    );

    lrb_mux #(.WORD_W(WORD_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .sel_buf(sel_buf), .dec_valid(dec_valid),
        .dec_word(dec_word), .buf_word(buf_word),
        .exe_valid(exe_valid), .exe_word(exe_word)
    );

    // R3
    store_only_while_fetching_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (fetch_en && exe_valid && !stall));
endmodule

// File: tb/sim_loop_replay_buf.sv
`timescale 1ns/1ps
module sim_loop_replay_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_en = 1'b0;
    logic        loop_start = 1'b0;
    logic [4:0]  loop_len = '0;
    logic [7:0]  loop_iters = '0;
    logic        stall = 1'b0;
    logic        dec_valid = 1'b0;
    logic [31:0] dec_word = '0;
    logic        fetch_en, exe_valid;
    logic [31:0] exe_word;

    int n_chk = 0;
    int n_bad = 0;

    int unsigned exp_q[$];
    int unsigned fq[$];
    bit   in_loop, elig_g, hold_v;
    int   cnt, len_g, it_g, stall_pct, bub_pct, fetch_on;
    logic [31:0] hold_w;
    string tag_g;

    always #10 clk = ~clk;

    loop_replay_buf u0 (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .loop_start(loop_start),
        .loop_len(loop_len), .loop_iters(loop_iters), .stall(stall),
        .dec_valid(dec_valid), .dec_word(dec_word), .fetch_en(fetch_en),
        .exe_valid(exe_valid), .exe_word(exe_word)
    );

    // Decoder model: a pure function of the instruction number.
    function automatic logic [31:0] decode(input int unsigned ins);
        return (ins * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input string tag, input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // One cycle: predict the fetch gate, drive inputs, compare accepted word.
    task automatic step(input bit ls);
        bit pred_rep, acc;
        @(negedge clk);
        pred_rep = in_loop && elig_g && cnt >= len_g && cnt < len_g * it_g;
        check(tag_g, fetch_en == !pred_rep, "fetch_en", {31'd0, fetch_en}, {31'd0, !pred_rep});
        if (fetch_en) fetch_on++;
        loop_start = ls;
        stall = ls ? 1'b0 : (($urandom % 100) < stall_pct);
        if (!ls && fetch_en && fq.size() > 0 && !(($urandom % 100) < bub_pct)) begin
            dec_valid = 1'b1;
            dec_word  = decode(fq[0]);
        end else begin
            dec_valid = 1'b0;
            dec_word  = '0;
        end
        #1;
        if (pred_rep) begin
            check("R5", exe_valid == 1'b1, "replay valid", {31'd0, exe_valid}, 32'd1);
            if (hold_v) check("R10", exe_word == hold_w, "held word", exe_word, hold_w);
        end
        hold_v = pred_rep && stall;
        hold_w = exe_word;
        acc = exe_valid && !stall;
        if (acc) begin
            if (exp_q.size() == 0) begin
                check(tag_g, 1'b0, "unexpected word", exe_word, 32'd0);
            end else begin
                check(tag_g, exe_word == decode(exp_q[0]), "word", exe_word, decode(exp_q[0]));
                void'(exp_q.pop_front());
            end
            if (in_loop) cnt++;
        end
        if (fetch_en && dec_valid && !stall) void'(fq.pop_front());
    endtask

    // Run pre-loop words, a loop, and post-loop words; returns fetch-enabled cycles.
    task automatic run_loop(input string tag, input int len, input int iters,
                            input bit use_buf, input int sp, input int bp,
                            output int fon);
        int base;
        base = $urandom % 100000 * 64;
        tag_g = tag; stall_pct = sp; bub_pct = bp; fetch_on = 0;
        buf_en = use_buf; hold_v = 1'b0;
        loop_len = 5'(len); loop_iters = 8'(iters);
        len_g = len; it_g = iters;
        elig_g = use_buf && len >= 1 && len <= 16 && iters >= 2;
        in_loop = 1'b0; cnt = 0;
        for (int k = 0; k < 3; k++) begin
            exp_q.push_back(base + k); fq.push_back(base + k);
        end
        while (exp_q.size() > 0) step(1'b0);
        step(1'b1);
        in_loop = 1'b1;
        for (int r = 0; r < iters; r++)
            for (int k = 0; k < len; k++) begin
                exp_q.push_back(base + 10 + k);
                if (!elig_g || r == 0) fq.push_back(base + 10 + k);
            end
        for (int k = 0; k < 3; k++) begin
            exp_q.push_back(base + 40 + k); fq.push_back(base + 40 + k);
        end
        while (exp_q.size() > 0) step(1'b0);
        tag_g = elig_g ? "R6" : tag;
        step(1'b0); step(1'b0);
        check(tag, fq.size() == 0, "fetch stream drained", fq.size(), 0);
        in_loop = 1'b0;
        fon = fetch_on;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R11 watchdog expired: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f_on, f_off;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state and transparency
        check("R1", fetch_en == 1'b1, "fetch_en after reset", {31'd0, fetch_en}, 32'd1);
        check("R1", exe_valid == 1'b0, "exe_valid after reset", {31'd0, exe_valid}, 32'd0);
        @(negedge clk);
        dec_valid = 1'b1; dec_word = 32'hCAFE_0001; stall = 1'b1;
        #1;
        check("R1", exe_word == 32'hCAFE_0001 && exe_valid, "pass-through", exe_word, 32'hCAFE_0001);
        @(negedge clk);
        dec_valid = 1'b0; stall = 1'b0;

        run_loop("R2", 4, 3, 1'b1, 0, 0, f_on);   // R3 R4 R5 basic buffered loop
        run_loop("R3", 16, 2, 1'b1, 30, 20, f_on); // full depth, stalls on boundaries
        run_loop("R7", 17, 2, 1'b1, 20, 10, f_on); // too long: bypass
        run_loop("R8", 5, 1, 1'b1, 20, 10, f_on);  // single pass: bypass
        run_loop("R12", 1, 5, 1'b1, 30, 40, f_on); // length 1 wrap, bubbles
        run_loop("R4", 7, 6, 1'b1, 25, 25, f_on);  // long run with stalls
        run_loop("R9", 6, 4, 1'b0, 0, 0, f_off);   // buffer off
        run_loop("R11", 6, 4, 1'b1, 0, 0, f_on);   // same loop, buffer on
        check("R11", f_off - f_on == 18, "fetch cycles saved", f_off - f_on, 18);
        $display("fetch-enabled cycles: buffer off %0d, buffer on %0d", f_off, f_on);
        run_loop("R10", 3, 9, 1'b1, 60, 30, f_on); // heavy stalls in replay
        run_loop("R5", 16, 3, 1'b1, 10, 10, f_on); // back-to-back loop
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule